// File: doc/BRIEF.md
# I/O Command Decoder with Illegal-Command Fault

This block sits between a processor's instruction sequencer and its I/O fabric. When an input or output instruction executes, the sequencer presents a 16-bit command word for one cycle. The block splits the word into a 7-bit channel group, a direction bit and an 8-bit command index. It then classifies the command and decides whether it is implemented. Every bit of the word takes part in the decision, so no two command codes alias.

Channel groups are assigned to one of four classes by parameterised group ranges:
- Mandatory groups accept every command.
- Reserved groups accept none.
- Optional and spare groups accept a command only when a per-group, per-direction presence bitmap marks it. The bitmap covers a low window of indices.

A legal command produces a one-cycle strobe, registered one cycle after acceptance, together with the decoded group and index. Low indices of mandatory groups go to the internal special registers. Everything else goes to the external device strobes.

An illegal command produces no strobe. Instead it sets the sticky illegal-I/O bit (bit 5 of the fault register), pulses a machine-error interrupt request and pulses an abort back to the sequencer.

Top module: `io_cmd_decoder`

## Requirements
- R1: The command word is decoded as group = word[15:9], direction = word[8] (1 = input, 0 = output) and index = word[7:0]. On the cycle after an accepted command, `sel_chan` and `sel_idx` carry its group and index.
- R2: Commands in groups below MAND_GROUPS (default 2) are always legal, whatever the bitmap holds.
- R3: Commands in optional groups (MAND_GROUPS up to RSV_BASE-1, default 2..95) are legal only when the index is below MAP_IDX (default 8) and the bitmap bit is set. By default the bitmap bit for group g, direction d and index i is set when (g + 3*i + d) mod 5 is not 0.
- R4: Commands in reserved groups (RSV_BASE up to SPARE_BASE-1, default 96..111) are always illegal.
- R5: Commands in spare groups (SPARE_BASE and above, default 112..127) follow the same bitmap rule as R3.
- R6: Each legal command gives exactly one strobe, high for one cycle, on the cycle after acceptance. The strobe is routed as follows:
  - a mandatory group with index below SPR_IDX_N (default 16) drives the special-register strobe;
  - any other legal command drives the device strobe;
  - an input command drives the read strobe and an output command drives the write strobe.
- R7: An illegal command gives no strobe. On the cycle after acceptance it drives `mchk_irq` and `cmd_abort` high for one cycle per illegal command.
- R8: `flt_ill_io` (fault bit 5) is set by every illegal command and stays set. A fault-register write (`flt_wr`) loads it with `flt_wr_bit`. An illegal command in the same cycle as a write wins.
- R9: While reset is asserted, all strobes, `mchk_irq`, `cmd_abort` and `flt_ill_io` are 0.
- R10: With `cmd_valid` low, no strobe, interrupt or abort is produced on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 16 | I/O command word |
| flt_wr | input | 1 | Fault-register write |
| flt_wr_bit | input | 1 | Value written to fault bit 5 |
| spr_rd_stb | output | 1 | Special-register read strobe |
| spr_wr_stb | output | 1 | Special-register write strobe |
| dev_rd_stb | output | 1 | External device read strobe |
| dev_wr_stb | output | 1 | External device write strobe |
| sel_chan | output | 7 | Decoded channel group |
| sel_idx | output | 8 | Decoded command index |
| mchk_irq | output | 1 | Machine-error interrupt request pulse |
| cmd_abort | output | 1 | Abort pulse to the sequencer |
| flt_ill_io | output | 1 | Sticky illegal-I/O fault bit (bit 5) |

## Verification
A wrong class boundary or a wrong bitmap lookup shows up exactly one cycle after the affected command word. It appears as a strobe where `mchk_irq` was due, or the reverse. A sweep of all 65536 words therefore exposes every misclassified code on its own cycle. A corrupted fault bit stays visible on `flt_ill_io` from the cycle after the fault until the next fault-register write. A wrongly ordered write/set priority appears on the single cycle following the coincident write.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned GRP_W    = 7;
  localparam int unsigned IDX_W    = 8;
  localparam int unsigned GRP_N    = 1 << GRP_W;
  localparam int unsigned MAP_IDX  = 8;
  localparam int unsigned MAP_BITS = GRP_N * 2 * MAP_IDX;

  typedef enum logic [1:0] {
    CLS_MAND  = 2'd0,
    CLS_OPT   = 2'd1,
    CLS_RSV   = 2'd2,
    CLS_SPARE = 2'd3
  } cmd_class_e;

  typedef struct packed {
    logic [GRP_W-1:0] grp;
    logic             dir_in;
    logic [IDX_W-1:0] idx;
  } cmd_fields_t;

  // presence bit for (group, direction, index) sits at ((g*2+d)*MAP_IDX + i)
  function automatic logic [MAP_BITS-1:0] default_impl_map();
    logic [MAP_BITS-1:0] m;
    m = '0;
    for (int g = 0; g < int'(GRP_N); g++) begin
      for (int d = 0; d < 2; d++) begin
        for (int i = 0; i < int'(MAP_IDX); i++) begin
          m[(g*2+d)*int'(MAP_IDX)+i] = ((g + 3*i + d) % 5) != 0;
        end
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/io_cmd_split.sv
module io_cmd_split
  import io_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output cmd_fields_t       fields_o
);
  // all sixteen bits are carried into the fields: no code aliasing (R1)
  assign fields_o = cmd_fields_t'(word_i);
endmodule

// File: rtl/io_cmd_classify.sv
module io_cmd_classify
  import io_dec_pkg::*;
#(
  parameter int unsigned          MAND_GROUPS = 2,
  parameter int unsigned          RSV_BASE    = 96,
  parameter int unsigned          SPARE_BASE  = 112,
  parameter int unsigned          SPR_IDX_N   = 16,
  parameter logic [MAP_BITS-1:0]  IMPL_MAP    = default_impl_map()
) (
  input  cmd_fields_t fields_i,
  output cmd_class_e  cls_o,
  output logic        legal_o,
  output logic        to_spr_o
);
  localparam int unsigned    MAP_SEL_W = $clog2(MAP_IDX);
  localparam int unsigned    MAP_POS_W = GRP_W + 1 + MAP_SEL_W;
  localparam logic [GRP_W:0] MAND_LIM  = (GRP_W+1)'(MAND_GROUPS);
  localparam logic [GRP_W:0] RSV_LIM   = (GRP_W+1)'(RSV_BASE);
  localparam logic [GRP_W:0] SPARE_LIM = (GRP_W+1)'(SPARE_BASE);
  localparam logic [IDX_W:0] WIN_LIM   = (IDX_W+1)'(MAP_IDX);
  localparam logic [IDX_W:0] SPR_LIM   = (IDX_W+1)'(SPR_IDX_N);

  logic [GRP_W:0]     grp_x;
  logic [IDX_W:0]     idx_x;
  logic [MAP_POS_W-1:0] map_pos;
  logic               in_win;
  logic               map_bit;

  assign grp_x   = {1'b0, fields_i.grp};
  assign idx_x   = {1'b0, fields_i.idx};
  assign map_pos = {fields_i.grp, fields_i.dir_in, fields_i.idx[MAP_SEL_W-1:0]};
  assign in_win  = idx_x < WIN_LIM;
  assign map_bit = IMPL_MAP[map_pos];

  always_comb begin
    if (grp_x < MAND_LIM)       cls_o = CLS_MAND;
    else if (grp_x < RSV_LIM)   cls_o = CLS_OPT;
    else if (grp_x < SPARE_LIM) cls_o = CLS_RSV;
    else                        cls_o = CLS_SPARE;
  end

  always_comb begin
    unique case (cls_o)
      CLS_MAND: legal_o = 1'b1;
      CLS_RSV:  legal_o = 1'b0;
      default:  legal_o = in_win & map_bit;
    endcase
  end

  assign to_spr_o = (cls_o == CLS_MAND) && (idx_x < SPR_LIM);
endmodule

// File: rtl/io_fault_ctl.sv
module io_fault_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ill_acc_i,
  input  logic flt_wr_i,
  input  logic flt_wr_bit_i,
  output logic flt_q_o,
  output logic irq_q_o,
  output logic abort_q_o
);
  logic flt_d;
  logic pulse_d;

  always_comb begin
    flt_d = flt_q_o;
    if (flt_wr_i)  flt_d = flt_wr_bit_i;
    if (ill_acc_i) flt_d = 1'b1;
    pulse_d = ill_acc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q_o   <= 1'b0;
      irq_q_o   <= 1'b0;
      abort_q_o <= 1'b0;
    end else begin
      flt_q_o   <= flt_d;
      irq_q_o   <= pulse_d;
      abort_q_o <= pulse_d;
    end
  end
endmodule

// File: rtl/io_cmd_decoder.sv
module io_cmd_decoder
  import io_dec_pkg::*;
#(
  parameter int unsigned          MAND_GROUPS = 2,
  parameter int unsigned          RSV_BASE    = 96,
  parameter int unsigned          SPARE_BASE  = 112,
  parameter int unsigned          SPR_IDX_N   = 16,
  parameter logic [MAP_BITS-1:0]  IMPL_MAP    = default_impl_map()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              flt_wr,
  input  logic              flt_wr_bit,
  output logic              spr_rd_stb,
  output logic              spr_wr_stb,
  output logic              dev_rd_stb,
  output logic              dev_wr_stb,
  output logic [GRP_W-1:0]  sel_chan,
  output logic [IDX_W-1:0]  sel_idx,
  output logic              mchk_irq,
  output logic              cmd_abort,
  output logic              flt_ill_io
);
  cmd_fields_t fields;
  cmd_class_e  cls;
  logic        legal;
  logic        to_spr;
  logic        ill_acc;
  logic [3:0]  stb_d, stb_q;
  logic [GRP_W-1:0] chan_d;
  logic [IDX_W-1:0] idx_d;
  logic        sel_en;

  io_cmd_split u_split (
    .word_i   (cmd_word),
    .fields_o (fields)
  );

  io_cmd_classify #(
    .MAND_GROUPS (MAND_GROUPS),
    .RSV_BASE    (RSV_BASE),
    .SPARE_BASE  (SPARE_BASE),
    .SPR_IDX_N   (SPR_IDX_N),
    .IMPL_MAP    (IMPL_MAP)
  ) u_classify (
    .fields_i (fields),
    .cls_o    (cls),
    .legal_o  (legal),
    .to_spr_o (to_spr)
  );

  assign ill_acc = cmd_valid & ~legal;

  io_fault_ctl u_fault (
    .clk          (clk),
    .rst_n        (rst_n),
    .ill_acc_i    (ill_acc),
    .flt_wr_i     (flt_wr),
    .flt_wr_bit_i (flt_wr_bit),
    .flt_q_o      (flt_ill_io),
    .irq_q_o      (mchk_irq),
    .abort_q_o    (cmd_abort)
  );

  // strobe vector order: {spr_rd, spr_wr, dev_rd, dev_wr}
  always_comb begin
    stb_d = '0;
    if (cmd_valid && legal) begin
      unique case ({to_spr, fields.dir_in})
        2'b11: stb_d = 4'b1000;
        2'b10: stb_d = 4'b0100;
        2'b01: stb_d = 4'b0010;
        default: stb_d = 4'b0001;
      endcase
    end
    sel_en = cmd_valid;
    chan_d = fields.grp;
    idx_d  = fields.idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
    end else begin
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_chan <= '0;
      sel_idx  <= '0;
    end else if (sel_en) begin
      sel_chan <= chan_d;
      sel_idx  <= idx_d;
    end
  end

  assign spr_rd_stb = stb_q[3];
  assign spr_wr_stb = stb_q[2];
  assign dev_rd_stb = stb_q[1];
  assign dev_wr_stb = stb_q[0];

  logic unused_cls;
  assign unused_cls = ^cls;
endmodule

// File: rtl/io_cmd_decoder_chk.sv
module io_cmd_decoder_chk
  import io_dec_pkg::*;
#(
  parameter int unsigned MAND_GROUPS = 2,
  parameter int unsigned RSV_BASE    = 96,
  parameter int unsigned SPARE_BASE  = 112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [WORD_W-1:0] cmd_word,
  input logic              flt_wr,
  input logic              flt_wr_bit,
  input logic              spr_rd_stb,
  input logic              spr_wr_stb,
  input logic              dev_rd_stb,
  input logic              dev_wr_stb,
  input logic [GRP_W-1:0]  sel_chan,
  input logic [IDX_W-1:0]  sel_idx,
  input logic              mchk_irq,
  input logic              cmd_abort,
  input logic              flt_ill_io
);
  localparam logic [GRP_W:0] MAND_LIM  = (GRP_W+1)'(MAND_GROUPS);
  localparam logic [GRP_W:0] RSV_LIM   = (GRP_W+1)'(RSV_BASE);
  localparam logic [GRP_W:0] SPARE_LIM = (GRP_W+1)'(SPARE_BASE);

  logic [GRP_W:0] grp_x;
  logic [3:0]     stbs;
  assign grp_x = {1'b0, cmd_word[15:9]};
  assign stbs  = {spr_rd_stb, spr_wr_stb, dev_rd_stb, dev_wr_stb};

  p_chan_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (sel_chan == $past(cmd_word[15:9])) && (sel_idx == $past(cmd_word[7:0])));

  p_mand_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (grp_x < MAND_LIM) |=> !mchk_irq && ($countones(stbs) == 1));

  p_rsv_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (grp_x >= RSV_LIM) && (grp_x < SPARE_LIM) |=> mchk_irq && cmd_abort);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stbs));

  p_irq_no_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_irq |-> (stbs == 4'b0000) && cmd_abort);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_irq |-> $past(cmd_valid));

  p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_irq |-> flt_ill_io);

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_ill_io && !flt_wr |=> flt_ill_io);

  p_fault_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_wr && flt_wr_bit |=> flt_ill_io);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (stbs == 4'b0000) && !mchk_irq && !cmd_abort);
endmodule

bind io_cmd_decoder io_cmd_decoder_chk #(
  .MAND_GROUPS (MAND_GROUPS),
  .RSV_BASE    (RSV_BASE),
  .SPARE_BASE  (SPARE_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_word   (cmd_word),
  .flt_wr     (flt_wr),
  .flt_wr_bit (flt_wr_bit),
  .spr_rd_stb (spr_rd_stb),
  .spr_wr_stb (spr_wr_stb),
  .dev_rd_stb (dev_rd_stb),
  .dev_wr_stb (dev_wr_stb),
  .sel_chan   (sel_chan),
  .sel_idx    (sel_idx),
  .mchk_irq   (mchk_irq),
  .cmd_abort  (cmd_abort),
  .flt_ill_io (flt_ill_io)
);

// File: tb/test_io_cmd_decoder.sv
module test_io_cmd_decoder;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_word;
  logic        flt_wr;
  logic        flt_wr_bit;
  logic        spr_rd_stb, spr_wr_stb, dev_rd_stb, dev_wr_stb;
  logic [6:0]  sel_chan;
  logic [7:0]  sel_idx;
  logic        mchk_irq, cmd_abort, flt_ill_io;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  io_cmd_decoder i_io_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .flt_wr(flt_wr), .flt_wr_bit(flt_wr_bit),
    .spr_rd_stb(spr_rd_stb), .spr_wr_stb(spr_wr_stb),
    .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb),
    .sel_chan(sel_chan), .sel_idx(sel_idx),
    .mchk_irq(mchk_irq), .cmd_abort(cmd_abort), .flt_ill_io(flt_ill_io)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic bit exp_legal(input logic [15:0] w);
    int g, d, i;
    g = int'(w[15:9]); d = int'(w[8]); i = int'(w[7:0]);
    if (g < 2) return 1;
    if (g >= 96 && g < 112) return 0;
    return (i < 8) && (((g + 3*i + d) % 5) != 0);
  endfunction

  function automatic string cls_tag(input logic [15:0] w);
    int g;
    g = int'(w[15:9]);
    if (g < 2)   return "R2";
    if (g < 96)  return "R3";
    if (g < 112) return "R4";
    return "R5";
  endfunction

  // outputs packed as {spr_rd, spr_wr, dev_rd, dev_wr, irq, abort}
  function automatic logic [5:0] exp_ctl(input logic [15:0] w);
    if (!exp_legal(w)) return 6'b000011;
    if (w[15:9] < 2 && w[7:0] < 16) return w[8] ? 6'b100000 : 6'b010000;
    return w[8] ? 6'b001000 : 6'b000100;
  endfunction

  function automatic logic [5:0] act_ctl();
    return {spr_rd_stb, spr_wr_stb, dev_rd_stb, dev_wr_stb, mchk_irq, cmd_abort};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    bit          prev_v;
    bit          exp_flt;
    rst_n = 0; cmd_valid = 0; cmd_word = '0; flt_wr = 0; flt_wr_bit = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset ctl", 32'(act_ctl()), 32'h0);
    chk("R9 reset fault", 32'(flt_ill_io), 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R10 idle ctl", 32'(act_ctl()), 32'h0);

    // exhaustive back-to-back sweep of every command word
    prev = '0; prev_v = 0; exp_flt = 0;
    for (int w = 0; w < 65536; w++) begin
      @(negedge clk);
      if (prev_v) begin
        if (!exp_legal(prev)) exp_flt = 1;
        chk({cls_tag(prev), "/R6/R7 ctl"}, 32'(act_ctl()), 32'(exp_ctl(prev)));
        chk("R1 fields", {17'h0, sel_chan, sel_idx}, {17'h0, prev[15:9], prev[7:0]});
        chk("R8 sticky", 32'(flt_ill_io), 32'(exp_flt));
      end
      cmd_valid = 1; cmd_word = w[15:0];
      prev = w[15:0]; prev_v = 1;
    end
    @(negedge clk);
    chk({cls_tag(prev), " last ctl"}, 32'(act_ctl()), 32'(exp_ctl(prev)));
    cmd_valid = 0;
    @(negedge clk);
    chk("R7 pulse ends / R10", 32'(act_ctl()), 32'h0);
    chk("R8 held", 32'(flt_ill_io), 32'h1);

    // clear through fault-register write
    flt_wr = 1; flt_wr_bit = 0;
    @(negedge clk);
    flt_wr = 0;
    chk("R8 cleared", 32'(flt_ill_io), 32'h0);
    @(negedge clk);
    chk("R8 stays clear", 32'(flt_ill_io), 32'h0);

    // write with bit=1 loads it
    flt_wr = 1; flt_wr_bit = 1;
    @(negedge clk);
    flt_wr = 0;
    chk("R8 write one", 32'(flt_ill_io), 32'h1);
    flt_wr = 1; flt_wr_bit = 0;
    @(negedge clk);
    chk("R8 clear again", 32'(flt_ill_io), 32'h0);

    // clear write coincides with reserved command: set wins
    flt_wr = 1; flt_wr_bit = 0; cmd_valid = 1; cmd_word = {7'd100, 1'b1, 8'd3};
    @(negedge clk);
    flt_wr = 0; cmd_valid = 0;
    chk("R8 set beats clear", 32'(flt_ill_io), 32'h1);
    chk("R4 irq", 32'(act_ctl()), 32'(6'b000011));
    @(negedge clk);
    chk("R7 single pulse", 32'(act_ctl()), 32'h0);

    // legal special-register read then idle
    flt_wr = 1; flt_wr_bit = 0;
    @(negedge clk);
    flt_wr = 0; cmd_valid = 1; cmd_word = {7'd1, 1'b1, 8'd15};
    @(negedge clk);
    cmd_valid = 0;
    chk("R6 spr read", 32'(act_ctl()), 32'(6'b100000));
    chk("R8 no fault on legal", 32'(flt_ill_io), 32'h0);
    @(negedge clk);
    chk("R6 one cycle strobe", 32'(act_ctl()), 32'h0);
    chk("R1 held when idle", {24'h0, sel_idx}, 32'd15);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule